// File: doc/BRIEF.md
# Byte-Oriented Instruction Execute Unit

This block carries out the register-file class of a 14-bit accumulator instruction set: every opcode whose two top bits are zero. Each cycle it takes the latched instruction word, a skip flag from the sequencer, the accumulator W, the carry flag and the indirect pointer. From these it presents a file-register address and a read strobe in the same cycle. It takes the returned operand through its ALU together with W and carry. On the next clock edge it registers either a file write (strobe, address and data) or a new W value, and registers the C, DC and Z updates that the function calls for.

Reads of some file registers (port latches, receive buffers) have side effects, so the read strobe is a port. Every executing opcode reads its operand, including those whose ALU result ignores it (clears and the W-to-file move). No-ops, skipped instructions and the control group (the opcodes with the top seven bits zero, such as subroutine return) raise no strobe of any kind. File address 0 is an indirect access through the pointer. A zero pointer reads as zero and is never strobed.

Top module: `byte_exec_unit`

## Requirements
- R1: The 7-bit file field is instr[6:0]. When it is non-zero, addr_o is that field zero-extended. When it is 0, addr_o equals fsr_i.
- R2: For a field of 0 with fsr_i equal to 0, the operand is taken as 0x00, and neither rd_en_o nor wr_en_o is raised.
- R3: For every executing opcode, rd_en_o is high in the same cycle that the instruction is presented. This includes clears (function 1) and the W-to-file move (function 0 with instr[7]=1).
- R4: Any word with instr[13:7] all zero (no-op, return and the rest of the control group) raises no read, no write, no W update and no flag update.
- R5: With skip_i high, the word presented causes no read, no write, no W update and no flag update.
- R6: The destination bit is instr[7]. When it is 0, the result goes to W (w_we_o). When it is 1, it goes to the file register (wr_en_o, wr_addr_o, wr_data_o). Both are registered one cycle after the instruction.
- R7: The function field is instr[11:8], with these results: 3 f-1, 4 f|w, 5 f&w, 6 f^w, 8 f, 9 ~f, 10 f+1, 11 f-1, 14 nibble swap of f, 15 f+1. Z is updated for 3,4,5,6,8,9,10. Z is not updated for 11,14,15.
- R8: Function 7 gives f+w and function 2 gives f-w. Both update Z, C and DC. C is the carry out of bit 7, and for subtraction it is 1 when no borrow occurs. DC is the same for the low nibble.
- R9: Function 1 gives 0x00 and sets Z to 1. Both destinations are accepted.
- R10: Function 12 rotates f right through carry and function 13 rotates it left through carry. Both update C only.
- R11: Function 0 with instr[7]=1 writes W to the file register and changes no flag.
- R12: Words whose top two bits are not 00 cause no read, no write and no update.
- R13: Out of reset, all strobes and update enables are low. Every write strobe follows a read strobe by exactly one cycle and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 14 | Latched instruction word |
| skip_i | input | 1 | Current word is skipped |
| w_i | input | 8 | Accumulator W |
| c_i | input | 1 | Carry flag |
| fsr_i | input | 8 | Indirect address pointer |
| rd_data_i | input | 8 | File read data for addr_o |
| addr_o | output | 8 | Effective file read address |
| rd_en_o | output | 1 | Operand read strobe |
| wr_en_o | output | 1 | File write strobe |
| wr_addr_o | output | 8 | File write address |
| wr_data_o | output | 8 | File write data |
| w_o | output | 8 | New W value |
| w_we_o | output | 1 | W update enable |
| c_o | output | 1 | New carry |
| dc_o | output | 1 | New digit carry |
| z_o | output | 1 | New zero flag |
| c_we_o | output | 1 | Carry update enable |
| dc_we_o | output | 1 | Digit carry update enable |
| z_we_o | output | 1 | Zero update enable |

## Verification
The checker assumes that the sequencer holds instr_i, skip_i and fsr_i steady across each clock edge. It also assumes that rd_data_i settles within the cycle from addr_o and that instructions arrive back to back with no handshake, so $past of the read strobe describes the instruction that caused the current write. The bench drives every input at the falling edge and holds it through the rising edge. It presents one word per cycle and sweeps all sixteen functions, both destinations, eight operand values each for W and the file, both carry values, the indirect pointer corners, the control words, skipped words and foreign classes.

// File: rtl/bx_pkg.sv
package bx_pkg;
  typedef enum logic [3:0] {
    FN_MOVW  = 4'h0, FN_CLR  = 4'h1, FN_SUB  = 4'h2, FN_DEC   = 4'h3,
    FN_IOR   = 4'h4, FN_AND  = 4'h5, FN_XOR  = 4'h6, FN_ADD   = 4'h7,
    FN_MOV   = 4'h8, FN_COM  = 4'h9, FN_INC  = 4'hA, FN_DECSZ = 4'hB,
    FN_RR    = 4'hC, FN_RL   = 4'hD, FN_SWAP = 4'hE, FN_INCSZ = 4'hF
  } alu_fn_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } flag_sel_t;
endpackage

// File: rtl/bx_decode.sv
module bx_decode
  import bx_pkg::*;
#(
  parameter int FW = 7,
  parameter int AW = 8,
  localparam int IW = FW + 7
) (
  input  logic [IW-1:0] instr_i,
  input  logic          skip_i,
  input  logic [AW-1:0] fsr_i,
  output alu_fn_e       fn_o,
  output logic [AW-1:0] addr_o,
  output logic          null_ind_o,
  output logic          rd_req_o,
  output logic          wr_req_o,
  output logic          w_req_o,
  output flag_sel_t     fsel_o
);
  localparam int FN_LSB = FW + 1;

  logic          in_class, is_ctrl, exec, dest_f;
  logic [FW-1:0] fld;
  flag_sel_t     fsel_raw;

  assign fld      = instr_i[FW-1:0];
  assign dest_f   = instr_i[FW];
  assign fn_o     = alu_fn_e'(instr_i[FN_LSB+3:FN_LSB]);
  assign in_class = (instr_i[IW-1:IW-2] == 2'b00) && !skip_i;
  // function 0 with d=0 is the no-op/control group: no operand fetch
  assign is_ctrl  = (fn_o == FN_MOVW) && !dest_f;
  assign exec     = in_class && !is_ctrl;

  assign null_ind_o = (fld == '0) && (fsr_i == '0);
  assign addr_o     = (fld == '0) ? fsr_i : AW'(fld);

  assign rd_req_o = exec && !null_ind_o;
  assign wr_req_o = exec && dest_f && !null_ind_o;
  assign w_req_o  = exec && !dest_f;

  always_comb begin
    fsel_raw = '0;
    unique case (fn_o)
      FN_ADD, FN_SUB:                 fsel_raw = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      FN_CLR, FN_DEC, FN_IOR, FN_AND,
      FN_XOR, FN_MOV, FN_COM, FN_INC: fsel_raw = '{c: 1'b0, dc: 1'b0, z: 1'b1};
      FN_RR, FN_RL:                   fsel_raw = '{c: 1'b1, dc: 1'b0, z: 1'b0};
      default:                        fsel_raw = '0;
    endcase
  end

  assign fsel_o = exec ? fsel_raw : '0;
endmodule

// File: rtl/bx_alu.sv
module bx_alu
  import bx_pkg::*;
#(
  parameter int DW = 8,
  localparam int HW = DW / 2
) (
  input  alu_fn_e       fn_i,
  input  logic [DW-1:0] f_i,
  input  logic [DW-1:0] w_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          dc_o,
  output logic          z_o
);
  logic          is_sub;
  logic [DW-1:0] w_op;
  logic [DW:0]   sum;
  logic [HW:0]   hsum;

  // shared adder: subtraction adds the complement plus one
  assign is_sub = (fn_i == FN_SUB);
  assign w_op   = is_sub ? ~w_i : w_i;
  assign sum    = {1'b0, f_i} + {1'b0, w_op} + (DW+1)'(is_sub);
  assign hsum   = {1'b0, f_i[HW-1:0]} + {1'b0, w_op[HW-1:0]} + (HW+1)'(is_sub);

  always_comb begin
    res_o = '0;
    c_o   = sum[DW];
    dc_o  = hsum[HW];
    unique case (fn_i)
      FN_MOVW:          res_o = w_i;
      FN_CLR:           res_o = '0;
      FN_SUB, FN_ADD:   res_o = sum[DW-1:0];
      FN_DEC, FN_DECSZ: res_o = f_i - DW'(1);
      FN_INC, FN_INCSZ: res_o = f_i + DW'(1);
      FN_IOR:           res_o = f_i | w_i;
      FN_AND:           res_o = f_i & w_i;
      FN_XOR:           res_o = f_i ^ w_i;
      FN_MOV:           res_o = f_i;
      FN_COM:           res_o = ~f_i;
      FN_RR: begin
        res_o = {c_i, f_i[DW-1:1]};
        c_o   = f_i[0];
      end
      FN_RL: begin
        res_o = {f_i[DW-2:0], c_i};
        c_o   = f_i[DW-1];
      end
      FN_SWAP:          res_o = {f_i[HW-1:0], f_i[DW-1:HW]};
      default:          res_o = '0;
    endcase
  end

  assign z_o = (res_o == '0);
endmodule

// File: rtl/byte_exec_unit.sv
module byte_exec_unit
  import bx_pkg::*;
#(
  parameter int FW = 7,
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int IW = FW + 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] instr_i,
  input  logic          skip_i,
  input  logic [DW-1:0] w_i,
  input  logic          c_i,
  input  logic [AW-1:0] fsr_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_en_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [DW-1:0] w_o,
  output logic          w_we_o,
  output logic          c_o,
  output logic          dc_o,
  output logic          z_o,
  output logic          c_we_o,
  output logic          dc_we_o,
  output logic          z_we_o
);
  alu_fn_e       fn;
  logic          null_ind, rd_req, wr_req, w_req;
  flag_sel_t     fsel;
  logic [DW-1:0] operand, res;
  logic          alu_c, alu_dc, alu_z;

  bx_decode #(.FW(FW), .AW(AW)) u_dec (
    .instr_i    (instr_i),
    .skip_i     (skip_i),
    .fsr_i      (fsr_i),
    .fn_o       (fn),
    .addr_o     (addr_o),
    .null_ind_o (null_ind),
    .rd_req_o   (rd_req),
    .wr_req_o   (wr_req),
    .w_req_o    (w_req),
    .fsel_o     (fsel)
  );

  // indirect through a zero pointer reads as zero without a bus access
  assign operand = null_ind ? '0 : rd_data_i;
  assign rd_en_o = rd_req;

  bx_alu #(.DW(DW)) u_alu (
    .fn_i  (fn),
    .f_i   (operand),
    .w_i   (w_i),
    .c_i   (c_i),
    .res_o (res),
    .c_o   (alu_c),
    .dc_o  (alu_dc),
    .z_o   (alu_z)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      w_o       <= '0;
      w_we_o    <= 1'b0;
      c_o       <= 1'b0;
      dc_o      <= 1'b0;
      z_o       <= 1'b0;
      c_we_o    <= 1'b0;
      dc_we_o   <= 1'b0;
      z_we_o    <= 1'b0;
    end else begin
      wr_en_o <= wr_req;
      w_we_o  <= w_req;
      c_we_o  <= fsel.c;
      dc_we_o <= fsel.dc;
      z_we_o  <= fsel.z;
      if (wr_req) begin
        wr_addr_o <= addr_o;
        wr_data_o <= res;
      end
      if (w_req)    w_o  <= res;
      if (fsel.c)   c_o  <= alu_c;
      if (fsel.dc)  dc_o <= alu_dc;
      if (fsel.z)   z_o  <= alu_z;
    end
  end
endmodule

// File: rtl/bx_exec_chk.sv
module bx_exec_chk #(
  parameter int FW = 7,
  parameter int AW = 8,
  localparam int IW = FW + 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [IW-1:0] instr_i,
  input logic          skip_i,
  input logic [AW-1:0] fsr_i,
  input logic [AW-1:0] addr_o,
  input logic          rd_en_o,
  input logic          wr_en_o,
  input logic          w_we_o,
  input logic          z_o,
  input logic          c_we_o,
  input logic          dc_we_o,
  input logic          z_we_o
);
  logic any_upd;
  assign any_upd = wr_en_o || w_we_o || c_we_o || dc_we_o || z_we_o;

  p_direct_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && instr_i[FW-1:0] != '0) |-> addr_o == AW'(instr_i[FW-1:0]));

  p_null_ind_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[FW-1:0] == '0 && fsr_i == '0) |-> !rd_en_o);

  p_ctrl_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[IW-1:FW] == '0) |-> !rd_en_o ##1 !any_upd);

  p_skip_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_i |-> !rd_en_o ##1 !any_upd);

  p_one_dest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && w_we_o));

  p_clr_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[IW-1:FW+1] == 6'b000001 && !skip_i) |=> (z_we_o && z_o));

  p_foreign_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[IW-1:IW-2] != 2'b00) |-> !rd_en_o ##1 !any_upd);

  p_wr_after_rd_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(rd_en_o));
endmodule

bind byte_exec_unit bx_exec_chk #(.FW(FW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .instr_i (instr_i),
  .skip_i  (skip_i),
  .fsr_i   (fsr_i),
  .addr_o  (addr_o),
  .rd_en_o (rd_en_o),
  .wr_en_o (wr_en_o),
  .w_we_o  (w_we_o),
  .z_o     (z_o),
  .c_we_o  (c_we_o),
  .dc_we_o (dc_we_o),
  .z_we_o  (z_we_o)
);

// File: tb/tb_byte_exec_unit.sv
module tb_byte_exec_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [13:0] instr_i;
  logic        skip_i, c_i;
  logic [7:0]  w_i, fsr_i, rd_data_i;
  logic [7:0]  addr_o, wr_addr_o, wr_data_o, w_o;
  logic        rd_en_o, wr_en_o, w_we_o, c_o, dc_o, z_o, c_we_o, dc_we_o, z_we_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  byte_exec_unit dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input int fn, input int f, input int w, input int c,
                       output int r, output bit uc, output bit udc, output bit uz,
                       output int nc, output int ndc);
    int s;
    uc = 0; udc = 0; uz = 0; nc = 0; ndc = 0; r = 0;
    case (fn)
      0:  r = w;
      1:  begin r = 0; uz = 1; end
      2:  begin s = f - w; r = s & 255; uc = 1; udc = 1; uz = 1;
                nc = (f >= w); ndc = ((f % 16) >= (w % 16)); end
      3:  begin r = (f + 255) % 256; uz = 1; end
      4:  begin r = f | w; uz = 1; end
      5:  begin r = f & w; uz = 1; end
      6:  begin r = f ^ w; uz = 1; end
      7:  begin s = f + w; r = s % 256; uc = 1; udc = 1; uz = 1;
                nc = (s > 255); ndc = ((f % 16 + w % 16) > 15); end
      8:  begin r = f; uz = 1; end
      9:  begin r = 255 - f; uz = 1; end
      10: begin r = (f + 1) % 256; uz = 1; end
      11: r = (f + 255) % 256;
      12: begin r = c * 128 + f / 2; uc = 1; nc = f % 2; end
      13: begin r = (f * 2) % 256 + c; uc = 1; nc = f / 128; end
      14: r = (f % 16) * 16 + f / 16;
      default: r = (f + 1) % 256;
    endcase
  endtask

  function automatic string data_req(input int fn, input bit d);
    if (fn == 0) return d ? "R11" : "R4";
    if (fn == 1) return "R9";
    if (fn == 2 || fn == 7) return "R8";
    if (fn == 12 || fn == 13) return "R10";
    return "R7";
  endfunction

  task automatic exec(input logic [13:0] ins, input bit sk, input logic [7:0] w,
                      input bit c, input logic [7:0] fsr, input logic [7:0] fv);
    bit cls, ctl, ex, nul, d, erd, ewr, eww, uc, udc, uz;
    int fn, fa, eaddr, opnd, r, nc, ndc;
    string sreq, dreq;
    instr_i = ins; skip_i = sk; w_i = w; c_i = c; fsr_i = fsr; rd_data_i = fv;
    #1;
    fn  = int'(ins[11:8]); d = ins[7]; fa = int'(ins[6:0]);
    cls = (ins[13:12] == 2'b00) && !sk;
    ctl = (fn == 0) && !d;
    ex  = cls && !ctl;
    nul = (fa == 0) && (fsr == 0);
    eaddr = (fa == 0) ? int'(fsr) : fa;
    erd = ex && !nul; ewr = ex && d && !nul; eww = ex && !d;
    opnd = nul ? 0 : int'(fv);
    sreq = sk ? "R5" : (ins[13:12] != 0) ? "R12" : ctl ? "R4" : nul ? "R2" : "R3";
    dreq = data_req(fn, d);
    model(fn, opnd, int'(w), int'(c), r, uc, udc, uz, nc, ndc);
    chk(sreq, "rd_en", int'(rd_en_o), int'(erd));
    if (erd) chk("R1", "addr", int'(addr_o), eaddr);
    @(negedge clk_i);
    chk(sreq == "R3" ? "R6" : sreq, "wr_en", int'(wr_en_o), int'(ewr));
    chk(sreq == "R3" ? "R6" : sreq, "w_we", int'(w_we_o), int'(eww));
    if (ewr) begin
      chk("R13", "wr_addr", int'(wr_addr_o), eaddr);
      chk(dreq, "wr_data", int'(wr_data_o), r);
    end
    if (eww) chk(dreq, "w_o", int'(w_o), r);
    chk(ex ? dreq : sreq, "c_we",  int'(c_we_o),  int'(ex && uc));
    chk(ex ? dreq : sreq, "dc_we", int'(dc_we_o), int'(ex && udc));
    chk(ex ? dreq : sreq, "z_we",  int'(z_we_o),  int'(ex && uz));
    if (ex && uc)  chk(dreq, "c",  int'(c_o),  nc);
    if (ex && udc) chk(dreq, "dc", int'(dc_o), ndc);
    if (ex && uz)  chk(dreq, "z",  int'(z_o),  int'(r == 0));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] vals [8] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFF, 8'h5A};
    logic [7:0] ptrs [4] = '{8'h00, 8'h01, 8'h80, 8'hFF};
    rst_ni = 0; instr_i = '0; skip_i = 0; w_i = '0; c_i = 0; fsr_i = '0; rd_data_i = '0;
    repeat (3) @(negedge clk_i);
    // R13: reset state
    chk("R13", "reset wr_en", int'(wr_en_o), 0);
    chk("R13", "reset w_we",  int'(w_we_o), 0);
    chk("R13", "reset flag we", int'({c_we_o, dc_we_o, z_we_o}), 0);
    rst_ni = 1;
    @(negedge clk_i);

    // main sweep: all functions, both destinations, operand and carry corners
    for (int fn = 0; fn < 16; fn++)
      for (int d = 0; d < 2; d++)
        for (int wi = 0; wi < 8; wi++)
          for (int fi = 0; fi < 8; fi++)
            for (int c = 0; c < 2; c++)
              exec({2'b00, 4'(fn), 1'(d), 7'h25}, 1'b0, vals[wi], 1'(c), 8'h33, vals[fi]);

    // R1/R2: indirect addressing with pointer corners
    for (int p = 0; p < 4; p++)
      for (int fn = 0; fn < 16; fn++)
        for (int d = 0; d < 2; d++)
          exec({2'b00, 4'(fn), 1'(d), 7'h00}, 1'b0, 8'h3C, 1'b1, ptrs[p], 8'hA5);

    // R1: every direct field value
    for (int fa = 1; fa < 128; fa++)
      exec({2'b00, 4'h8, 1'b0, 7'(fa)}, 1'b0, 8'h00, 1'b0, 8'h99, 8'(fa));

    // R9: both accepted clear-W encodings, R4: control group words
    exec(14'h0100, 1'b0, 8'hFF, 1'b0, 8'h00, 8'h77);
    exec(14'h0103, 1'b0, 8'hFF, 1'b0, 8'h00, 8'h77);
    for (int lo = 0; lo < 128; lo++)
      exec(14'(lo), 1'b0, 8'h12, 1'b1, 8'h00, 8'hEE);

    // R5: skipped words of every shape
    for (int fn = 0; fn < 16; fn++)
      for (int d = 0; d < 2; d++)
        exec({2'b00, 4'(fn), 1'(d), 7'h06}, 1'b1, 8'h01, 1'b1, 8'h40, 8'h02);

    // R12: other instruction classes
    for (int t = 1; t < 4; t++)
      for (int k = 0; k < 64; k++)
        exec({2'(t), 12'(k * 61 + 7)}, 1'b0, 8'h55, 1'b0, 8'h20, 8'h00);

    // R13: write pulse returns low on the following no-op
    exec(14'h00A5, 1'b0, 8'h42, 1'b0, 8'h00, 8'h00);
    exec(14'h0000, 1'b0, 8'h42, 1'b0, 8'h00, 8'h00);
    chk("R13", "pulse width", int'(wr_en_o), 0);

    finish_run();
  end
endmodule